// File: doc/BRIEF.md
# Infrared Carrier Generator with Two-Pair Frequency Shift

This block produces a square carrier for an infrared transmitter. The high and low parts of each carrier period are each a number of input clock cycles, taken from one of two 6-bit count pairs: a primary pair and a secondary pair. In fixed mode the primary pair sets every period. In frequency-shift mode a select input from the modulator picks the pair. The block samples that input only when a new period begins, so it never cuts a phase short.

Software programs the block through a small register bus, and reads come back combinationally. A control register holds an enable bit and a mode bit. While the enable bit is clear, the output pin is driven by a direct-drive latch instead of the carrier. Bit 7 of any write to either primary count register also updates that latch. The count registers have no reset, so their contents survive a reset. Software must load nonzero counts before it sets the enable bit.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset the enable bit, the mode bit and the direct-drive latch are all 0. The control register reads 0x00 and `carrier_o` is 0.
- R2: A write to address 1 (primary high) or address 2 (primary low) loads data bit 7 into the direct-drive latch. Writes to address 0 (control), 3 (secondary high) and 4 (secondary low) leave the latch unchanged.
- R3: While the enable bit (control bit 0) is clear, `carrier_o` equals the direct-drive latch. This holds from the cycle right after the write that clears the enable bit.
- R4: The first clock edge after the write that sets the enable bit starts a high phase. The write's own edge leaves the pin showing the latch. Each high phase lasts exactly the high count of the active pair and each low phase lasts exactly its low count, both in clock cycles.
- R5: In fixed mode (control bit 1 = 0) the primary pair is always used, whatever the level of `pair_sel_i`.
- R6: In frequency-shift mode (control bit 1 = 1) the block samples `pair_sel_i` at the start of each period. The value 0 selects the primary pair and 1 selects the secondary pair.
- R7: A change of `pair_sel_i` during a period does not affect that period. It takes effect at the start of the next period.
- R8: Read data by address: 0 gives {6'b0, mode, enable}, 1 to 4 give {2'b00, count[5:0]}, and any other address gives 0x00. Bit 7 of a count register always reads 0, and so does bit 6, which includes the secondary low register.
- R9: Reset does not clear the four count registers. A value written before reset reads back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; counts are in cycles of this clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational from address) |
| pair_sel_i | input | 1 | Pair select from the modulator (frequency-shift mode) |
| carrier_o | output | 1 | Carrier, or the direct-drive latch while disabled |

## Verification
The assertions check five things on every cycle:
- the pin follows the latch whenever the block is disabled;
- writes to the primary registers load the latch, and writes to the other registers leave it alone;
- a start always begins high at count one;
- fixed mode always starts on the primary pair;
- the active pair cannot change except at a period boundary.

Only the bench scenarios can show the measured high and low widths against the programmed counts, and the one-cycle start latency after the enabling write. They also cover the mid-period select change that shows up only in the following period, the read-back masking, and count retention across reset.

// File: rtl/ir_carrier_pkg.sv
package ir_carrier_pkg;
  localparam int unsigned ADDR_W     = 3;
  localparam int unsigned A_CTRL     = 0;
  localparam int unsigned A_PRI_HI   = 1;
  localparam int unsigned A_PRI_LO   = 2;
  localparam int unsigned A_SEC_HI   = 3;
  localparam int unsigned A_SEC_LO   = 4;
  localparam int unsigned N_CNT_REGS = 4;

  typedef struct packed {
    logic fsk;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/ir_carrier_regs.sv
module ir_carrier_regs
  import ir_carrier_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic              latch_o,
  output logic [CNT_W-1:0]  pri_hi_o,
  output logic [CNT_W-1:0]  pri_lo_o,
  output logic [CNT_W-1:0]  sec_hi_o,
  output logic [CNT_W-1:0]  sec_lo_o
);
  localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] AD_PRI_HI = ADDR_W'(A_PRI_HI);
  localparam logic [ADDR_W-1:0] AD_PRI_LO = ADDR_W'(A_PRI_LO);

  logic [CNT_W-1:0] cnt_q [N_CNT_REGS];
  ctrl_t            ctrl_q;
  logic             latch_q;

  // control and direct-drive latch: reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      latch_q <= 1'b0;
    end else if (wr_i) begin
      if (addr_i == AD_CTRL) ctrl_q <= ctrl_t'(wdata_i[1:0]);
      if (addr_i == AD_PRI_HI || addr_i == AD_PRI_LO) latch_q <= wdata_i[DATA_W-1];
    end
  end

  // count storage: deliberately no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(N_CNT_REGS); i++) begin
      if (wr_i && addr_i == ADDR_W'(int'(A_PRI_HI) + i)) cnt_q[i] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == AD_CTRL) rdata_o[1:0] = ctrl_q;
    for (int i = 0; i < int'(N_CNT_REGS); i++) begin
      if (addr_i == ADDR_W'(int'(A_PRI_HI) + i)) rdata_o[CNT_W-1:0] = cnt_q[i];
    end
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata_i[DATA_W-2:CNT_W];

  assign ctrl_o   = ctrl_q;
  assign latch_o  = latch_q;
  assign pri_hi_o = cnt_q[0];
  assign pri_lo_o = cnt_q[1];
  assign sec_hi_o = cnt_q[2];
  assign sec_lo_o = cnt_q[3];
endmodule

// File: rtl/ir_carrier_timer.sv
module ir_carrier_timer #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             fsk_i,
  input  logic             pair_sel_i,
  input  logic [CNT_W-1:0] pri_hi_i,
  input  logic [CNT_W-1:0] pri_lo_i,
  input  logic [CNT_W-1:0] sec_hi_i,
  input  logic [CNT_W-1:0] sec_lo_i,
  output logic             running_o,
  output logic             phase_o,
  output logic             sel_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             running_q, phase_q, sel_q;
  logic [CNT_W-1:0] cnt_q, hi_act, lo_act;
  logic             next_sel;

  assign next_sel = fsk_i & pair_sel_i;
  assign hi_act   = sel_q ? sec_hi_i : pri_hi_i;
  assign lo_act   = sel_q ? sec_lo_i : pri_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      phase_q   <= 1'b0;
      sel_q     <= 1'b0;
      cnt_q     <= '0;
    end else if (!en_i) begin
      running_q <= 1'b0;
      phase_q   <= 1'b0;
      cnt_q     <= '0;
    end else if (!running_q) begin
      running_q <= 1'b1;
      phase_q   <= 1'b1;
      cnt_q     <= ONE;
      sel_q     <= next_sel;
    end else if (phase_q) begin
      if (cnt_q == hi_act) begin
        phase_q <= 1'b0;
        cnt_q   <= ONE;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end else begin
      if (cnt_q == lo_act) begin
        // period boundary: pair choice is resampled only here
        phase_q <= 1'b1;
        cnt_q   <= ONE;
        sel_q   <= next_sel;
      end else begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign running_o = running_q;
  assign phase_o   = phase_q;
  assign sel_o     = sel_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/ir_carrier_out.sv
module ir_carrier_out (
  input  logic en_i,
  input  logic running_i,
  input  logic phase_i,
  input  logic latch_i,
  output logic carrier_o
);
  assign carrier_o = (en_i && running_i) ? phase_i : latch_i;
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import ir_carrier_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              pair_sel_i,
  output logic              carrier_o
);
  ctrl_t            ctrl;
  logic             latch, running, phase, sel;
  logic [CNT_W-1:0] pri_hi, pri_lo, sec_hi, sec_lo, cnt;

  ir_carrier_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .ctrl_o   (ctrl),
    .latch_o  (latch),
    .pri_hi_o (pri_hi),
    .pri_lo_o (pri_lo),
    .sec_hi_o (sec_hi),
    .sec_lo_o (sec_lo)
  );

  ir_carrier_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl.en),
    .fsk_i      (ctrl.fsk),
    .pair_sel_i (pair_sel_i),
    .pri_hi_i   (pri_hi),
    .pri_lo_i   (pri_lo),
    .sec_hi_i   (sec_hi),
    .sec_lo_i   (sec_lo),
    .running_o  (running),
    .phase_o    (phase),
    .sel_o      (sel),
    .cnt_o      (cnt)
  );

  ir_carrier_out u_out (
    .en_i      (ctrl.en),
    .running_i (running),
    .phase_i   (phase),
    .latch_i   (latch),
    .carrier_o (carrier_o)
  );
endmodule

// File: rtl/ir_carrier_gen_chk.sv
module ir_carrier_gen_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_wr_i,
  input logic [2:0]        reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic              en_i,
  input logic              fsk_i,
  input logic              latch_i,
  input logic              running_i,
  input logic              phase_i,
  input logic              sel_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  pri_lo_i,
  input logic [CNT_W-1:0]  sec_lo_i,
  input logic              carrier_o
);
  logic [CNT_W-1:0] lo_act;
  logic             pri_wr, other_wr, period_end;

  assign lo_act     = sel_i ? sec_lo_i : pri_lo_i;
  assign pri_wr     = reg_wr_i && (reg_addr_i == 3'd1 || reg_addr_i == 3'd2);
  assign other_wr   = reg_wr_i && (reg_addr_i == 3'd0 || reg_addr_i == 3'd3 || reg_addr_i == 3'd4);
  assign period_end = !phase_i && (cnt_i == lo_act);

  assert_pin_follows_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> carrier_o == latch_i);

  assert_pri_write_loads_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pri_wr |=> latch_i == $past(reg_wdata_i[DATA_W-1]));

  assert_other_write_keeps_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    other_wr |=> $stable(latch_i));

  assert_start_is_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_i) |-> phase_i && carrier_o && cnt_i == {{(CNT_W-1){1'b0}}, 1'b1});

  assert_fixed_mode_primary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !running_i && !fsk_i |=> !sel_i);

  assert_pair_held_in_period_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && running_i && !period_end |=> $stable(sel_i));
endmodule

bind ir_carrier_gen ir_carrier_gen_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .en_i        (ctrl.en),
  .fsk_i       (ctrl.fsk),
  .latch_i     (latch),
  .running_i   (running),
  .phase_i     (phase),
  .sel_i       (sel),
  .cnt_i       (cnt),
  .pri_lo_i    (pri_lo),
  .sec_lo_i    (sec_lo),
  .carrier_o   (carrier_o)
);

// File: tb/ir_carrier_gen_tb.sv
`timescale 1ns/1ps
module ir_carrier_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       psel = 1'b0;
  logic       car;
  int         checks = 0;
  int         fails = 0;

  always #2.5 clk = ~clk;

  ir_carrier_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .pair_sel_i(psel), .carrier_o(car)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(rdata == exp, tag, rdata, exp);
  endtask

  task automatic wait_rise();
    logic prev;
    @(negedge clk);
    prev = car;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!prev && car) return;
      prev = car;
    end
  endtask

  // starts at a negedge where the carrier has just gone high
  task automatic measure(output int h, output int l);
    h = 0; l = 0;
    while (car && h < 200) begin h++; @(negedge clk); end
    while (!car && l < 200) begin l++; @(negedge clk); end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk(car == 1'b0, "R1 carrier after reset", car, 0);
    rd_chk(3'd0, 8'h00, "R1 ctrl after reset");
  endtask

  task automatic t_latch();
    wr_reg(3'd1, 8'h85);
    chk(car == 1'b1, "R2 pri_hi bit7 loads latch", car, 1);
    chk(car == 1'b1, "R3 pin shows latch while disabled", car, 1);
    wr_reg(3'd3, 8'h02);
    chk(car == 1'b1, "R2 sec_hi write keeps latch", car, 1);
    wr_reg(3'd4, 8'h07);
    chk(car == 1'b1, "R2 sec_lo write keeps latch", car, 1);
    wr_reg(3'd0, 8'h00);
    chk(car == 1'b1, "R2 ctrl write keeps latch", car, 1);
    wr_reg(3'd2, 8'h03);
    chk(car == 1'b0, "R2 pri_lo bit7 clears latch", car, 0);
    wr_reg(3'd2, 8'h83);
    chk(car == 1'b1, "R2 pri_lo bit7 sets latch", car, 1);
    wr_reg(3'd2, 8'h03);
  endtask

  task automatic t_readback();
    wr_reg(3'd4, 8'hFF);
    rd_chk(3'd4, 8'h3F, "R8 sec_lo bits 7 and 6 read 0");
    wr_reg(3'd3, 8'h62);
    rd_chk(3'd3, 8'h22, "R8 sec_hi masked");
    wr_reg(3'd0, 8'hFE);
    rd_chk(3'd0, 8'h02, "R8 ctrl read");
    wr_reg(3'd0, 8'h00);
    rd_chk(3'd7, 8'h00, "R8 unused address");
    wr_reg(3'd3, 8'h02);
    wr_reg(3'd4, 8'h07);
    rd_chk(3'd1, 8'h05, "R8 pri_hi masked");
    rd_chk(3'd2, 8'h03, "R8 pri_lo");
  endtask

  task automatic t_time_mode();
    int h, l;
    psel = 1'b1;
    wr_reg(3'd0, 8'h01);
    chk(car == 1'b0, "R4 write edge still shows latch", car, 0);
    @(negedge clk);
    chk(car == 1'b1, "R4 high one cycle after enable", car, 1);
    measure(h, l);
    chk(h == 5, "R4 first high width", h, 5);
    chk(l == 3, "R4 first low width", l, 3);
    measure(h, l);
    chk(h == 5 && l == 3, "R5 select ignored in fixed mode", h * 100 + l, 503);
    wr_reg(3'd1, 8'h85);
    wr_reg(3'd0, 8'h00);
    chk(car == 1'b1, "R3 disable returns pin to latch", car, 1);
    repeat (4) begin
      @(negedge clk);
      chk(car == 1'b1, "R3 pin held at latch", car, 1);
    end
    wr_reg(3'd1, 8'h05);
    psel = 1'b0;
  endtask

  task automatic t_fsk();
    int h, l;
    wr_reg(3'd0, 8'h03);
    wait_rise();
    measure(h, l);
    chk(h == 5 && l == 3, "R6 select 0 uses primary", h * 100 + l, 503);
    psel = 1'b1; // this period already began on the primary pair
    measure(h, l);
    chk(h == 5 && l == 3, "R7 mid-period change deferred", h * 100 + l, 503);
    psel = 1'b0;
    measure(h, l);
    chk(h == 2 && l == 7, "R6 select 1 uses secondary", h * 100 + l, 207);
    measure(h, l);
    chk(h == 5 && l == 3, "R7 return to primary at boundary", h * 100 + l, 503);
    wr_reg(3'd0, 8'h00);
  endtask

  task automatic t_retention();
    wr_reg(3'd1, 8'h2A);
    wr_reg(3'd4, 8'h11);
    do_reset();
    rd_chk(3'd1, 8'h2A, "R9 pri_hi kept over reset");
    rd_chk(3'd4, 8'h11, "R9 sec_lo kept over reset");
    rd_chk(3'd0, 8'h00, "R1 ctrl cleared by reset");
    chk(car == 1'b0, "R1 latch cleared by reset", car, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_readback();
    t_time_mode();
    t_fsk();
    t_retention();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule